// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block turns single requests from a host into complete bus transactions on an asynchronous parallel NOR flash. Each request carries an opcode, a word address and a data word. Program and erase requests become a train of command writes. The first writes are unlock writes to two fixed addresses, and the last write is the command itself. Chip enable, write enable and output enable are timed by counters whose lengths come from nanosecond minimums and the clock period. The counts are rounded up to whole cycles.

After the last command write, the sequencer polls the target address with reads. It watches bit 7 of every byte lane. While the device is busy, that bit reads as the complement of the value being written. An erase writes all ones, so a busy device returns 0 in bit 7. Once bit 7 matches on every lane, the sequencer returns a response without error. If polling runs past a limit set per operation, the sequencer reports an error, pulses the device reset and goes back to idle. A plain read opcode and a device-reset opcode use the same bus timing.

Command bytes are copied onto every byte lane of the data bus. This lets a wide bus made of several byte-wide devices in parallel take each command on all of them together.

Top module: `flash_seq`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle, with no bus strobe active. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` then stays low until one cycle after the single-cycle `rsp_valid_o` pulse.
- R2: Opcode 1 (program) makes exactly four writes, as (address, byte): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then the request data at the request address. Each command byte is copied onto every byte lane.
- R3: Opcode 2 (sector erase) makes exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then byte 30h at the request address.
- R4: Opcode 3 (chip erase) makes the same first five writes as R3, then byte 10h at 5555h.
- R5: Each write holds `fl_we_no` and `fl_ce_no` low for exactly ceil(T_WP_NS/clock) cycles. The high time between writes is at least max(ceil(T_WPH_NS/clock), ceil(T_WC_NS/clock) minus the low time) cycles.
- R6: `fl_addr_o` and `fl_dq_o` stay stable while write enable is low. `fl_dq_oe_o` is high only while `fl_oe_no` is high. Write enable and output enable are never low together.
- R7: Output enable has been high for at least one cycle before every falling edge of write enable, and before every falling edge of output enable.
- R8: Polling reads the request address. The operation completes when bit 7 of every byte lane equals that lane's written bit 7 for a program, or equals 1 for an erase. Completion gives `rsp_err_o` = 0. The number of polling reads is the number of busy reads plus one.
- R9: If the count of polling cycles has reached the limit for the opcode when a busy read completes, the response has `rsp_err_o` = 1 and is preceded by one device-reset pulse.
- R10: Opcode 4 (reset) holds `fl_rst_no` low for exactly ceil(T_RP_NS/clock) cycles, makes no bus read or write, and responds with `rsp_err_o` = 0.
- R11: Opcode 0 (read) holds output enable and chip enable low for exactly ceil(T_ACC_NS/clock) cycles at the request address. It returns the bus data sampled in the last of those cycles on `rsp_data_o`, with `rsp_err_o` = 0.
- R12: Opcodes 5 to 7 cause no bus activity and no reset pulse. They respond within three cycles with `rsp_err_o` = 1.
- R13: After reset, `req_ready_o`, `fl_ce_no`, `fl_we_no`, `fl_oe_no` and `fl_rst_no` are high, and `fl_dq_oe_o` and `rsp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_op_i | input | 3 | Opcode: 0 read, 1 program, 2 sector erase, 3 chip erase, 4 reset |
| req_addr_i | input | AW | Word address |
| req_data_i | input | DW | Program data |
| rsp_valid_o | output | 1 | Single-cycle response strobe |
| rsp_err_o | output | 1 | Response error (timeout or bad opcode) |
| rsp_data_o | output | DW | Read data |
| fl_addr_o | output | AW | Flash address |
| fl_dq_o | output | DW | Flash write data |
| fl_dq_oe_o | output | 1 | Drive enable for write data |
| fl_dq_i | input | DW | Flash read data |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_we_no | output | 1 | Write enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |
| fl_rst_no | output | 1 | Device reset, active low |

## Verification
The bench uses a 21-bit address, a 16-bit data bus with two byte lanes and a 4000 ps clock. With these values the write pulse is 12 cycles, the high time is 11 cycles, the access time is 23 cycles and the reset pulse is 125 cycles. The timeouts are reduced to 2, 3 and 4 microseconds, which gives 500 to 1000 polling cycles. This makes the timeout path and reset-after-timeout reachable in a short run. Two lanes let the bench check, lane by lane, that commands are copied and that bit 7 is compared on each lane with a different expected value.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [2:0] OP_READ   = 3'd0;
  localparam logic [2:0] OP_PROG   = 3'd1;
  localparam logic [2:0] OP_SERASE = 3'd2;
  localparam logic [2:0] OP_CERASE = 3'd3;
  localparam logic [2:0] OP_RESET  = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_WLO, S_WHI, S_PGAP, S_PRD, S_RD, S_RST, S_RESP
  } seq_state_e;

  // minimum time in ns -> whole clock cycles, rounded up, at least one
  function automatic int ns2cyc(int ns, int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_seq_tmr.sv
module flash_seq_tmr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/flash_seq_cmd.sv
module flash_seq_cmd
  import flash_seq_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter logic [AW-1:0] UNLOCK_A1 = AW'('h5555),
  parameter logic [AW-1:0] UNLOCK_A2 = AW'('h2AAA)
) (
  input  logic [2:0]    op_i,
  input  logic [2:0]    step_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [2:0]    nsteps_o
);
  localparam int LANES = DW / 8;

  logic [7:0] cbyte;
  logic       use_data;

  always_comb begin
    cbyte    = 8'hAA;
    waddr_o  = UNLOCK_A1;
    use_data = 1'b0;
    nsteps_o = (op_i == OP_PROG) ? 3'd4 : 3'd6;
    case (step_i)
      3'd0: begin cbyte = 8'hAA; waddr_o = UNLOCK_A1; end
      3'd1: begin cbyte = 8'h55; waddr_o = UNLOCK_A2; end
      3'd2: begin
        cbyte   = (op_i == OP_PROG) ? 8'hA0 : 8'h80;
        waddr_o = UNLOCK_A1;
      end
      3'd3: begin
        if (op_i == OP_PROG) begin
          use_data = 1'b1;
          waddr_o  = addr_i;
        end else begin
          cbyte   = 8'hAA;
          waddr_o = UNLOCK_A1;
        end
      end
      3'd4: begin cbyte = 8'h55; waddr_o = UNLOCK_A2; end
      default: begin
        if (op_i == OP_CERASE) begin
          cbyte   = 8'h10;
          waddr_o = UNLOCK_A1;
        end else begin
          cbyte   = 8'h30;
          waddr_o = addr_i;
        end
      end
    endcase
  end

  // command byte copied onto every lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wdata_o[8*l +: 8] = use_data ? data_i[8*l +: 8] : cbyte;
  end
endmodule

// File: rtl/flash_seq_poll.sv
module flash_seq_poll #(
  parameter int LANES = 2
) (
  input  logic             is_prog_i,
  input  logic [LANES-1:0] rd_b7_i,
  input  logic [LANES-1:0] wr_b7_i,
  output logic             done_o
);
  logic [LANES-1:0] match;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign match[l] = rd_b7_i[l] == (is_prog_i ? wr_b7_i[l] : 1'b1);
  end

  assign done_o = &match;
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW             = 21,
  parameter int DW             = 16,
  parameter int CLK_PS         = 4000,
  parameter int T_WP_NS        = 45,
  parameter int T_WPH_NS       = 20,
  parameter int T_WC_NS        = 90,
  parameter int T_ACC_NS       = 90,
  parameter int T_RP_NS        = 500,
  parameter int PROG_TMO_US    = 50,
  parameter int SERASE_TMO_US  = 15_000_000,
  parameter int CERASE_TMO_US  = 120_000_000,
  parameter logic [AW-1:0] UNLOCK_A1 = AW'('h5555),
  parameter logic [AW-1:0] UNLOCK_A2 = AW'('h2AAA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [2:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_data_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [DW-1:0] fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no,
  output logic          fl_rst_no
);
  localparam int LANES  = DW / 8;
  localparam int WP_C   = ns2cyc(T_WP_NS, CLK_PS);
  localparam int WPH_C  = ns2cyc(T_WPH_NS, CLK_PS);
  localparam int WC_C   = ns2cyc(T_WC_NS, CLK_PS);
  localparam int WH_C   = imax(WPH_C, WC_C - WP_C);
  localparam int ACC_C  = ns2cyc(T_ACC_NS, CLK_PS);
  localparam int RST_C  = ns2cyc(T_RP_NS, CLK_PS);
  localparam int MAX_C  = imax(imax(WP_C, WH_C), imax(ACC_C, RST_C));
  localparam int TMR_W  = $clog2(MAX_C + 1);

  localparam longint PROG_LIM = longint'(PROG_TMO_US)   * 1_000_000 / longint'(CLK_PS);
  localparam longint SE_LIM   = longint'(SERASE_TMO_US) * 1_000_000 / longint'(CLK_PS);
  localparam longint CE_LIM   = longint'(CERASE_TMO_US) * 1_000_000 / longint'(CLK_PS);
  localparam longint MAX_LIM  = (PROG_LIM > SE_LIM) ? ((PROG_LIM > CE_LIM) ? PROG_LIM : CE_LIM)
                                                    : ((SE_LIM > CE_LIM) ? SE_LIM : CE_LIM);
  localparam int TMO_W = $clog2(MAX_LIM + 1);

  seq_state_e state_q, state_d;
  logic [2:0]       step_q, step_d, op_q, nsteps;
  logic [AW-1:0]    addr_q, cmd_addr;
  logic [DW-1:0]    data_q, cmd_data, rdata_q;
  logic             err_q, tmr_zero, tmr_load, poll_done, accept;
  logic [TMR_W-1:0] tmr_val;
  logic [TMO_W-1:0] tmo_q, tmo_lim;
  logic [LANES-1:0] rd_b7, wr_b7;

  assign accept = (state_q == S_IDLE) && req_valid_i;

  flash_seq_cmd #(
    .AW(AW), .DW(DW), .UNLOCK_A1(UNLOCK_A1), .UNLOCK_A2(UNLOCK_A2)
  ) u_cmd (
    .op_i(op_q), .step_i(step_d), .addr_i(addr_q), .data_i(data_q),
    .waddr_o(cmd_addr), .wdata_o(cmd_data), .nsteps_o(nsteps)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_b7
    assign rd_b7[l] = fl_dq_i[8*l + 7];
    assign wr_b7[l] = data_q[8*l + 7];
  end

  flash_seq_poll #(.LANES(LANES)) u_poll (
    .is_prog_i(op_q == OP_PROG), .rd_b7_i(rd_b7), .wr_b7_i(wr_b7), .done_o(poll_done)
  );

  always_comb begin
    case (op_q)
      OP_PROG:   tmo_lim = TMO_W'(PROG_LIM);
      OP_SERASE: tmo_lim = TMO_W'(SE_LIM);
      default:   tmo_lim = TMO_W'(CE_LIM);
    endcase
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      S_IDLE: if (req_valid_i) begin
        step_d = 3'd0;
        case (req_op_i)
          OP_READ, OP_PROG, OP_SERASE, OP_CERASE: state_d = S_GAP;
          OP_RESET: state_d = S_RST;
          default:  state_d = S_RESP;
        endcase
      end
      S_GAP:  state_d = (op_q == OP_READ) ? S_RD : S_WLO;
      S_WLO:  if (tmr_zero) state_d = S_WHI;
      S_WHI:  if (tmr_zero) begin
        if (step_q == nsteps - 3'd1) state_d = S_PGAP;
        else begin
          state_d = S_WLO;
          step_d  = step_q + 3'd1;
        end
      end
      S_PGAP: state_d = S_PRD;
      S_PRD:  if (tmr_zero) begin
        if (poll_done)             state_d = S_RESP;
        else if (tmo_q >= tmo_lim) state_d = S_RST;
        else                       state_d = S_PGAP;
      end
      S_RD:   if (tmr_zero) state_d = S_RESP;
      S_RST:  if (tmr_zero) state_d = S_RESP;
      default: state_d = S_IDLE;
    endcase
  end

  // each state entry reloads the phase timer with its length minus one
  assign tmr_load = (state_d != state_q);
  always_comb begin
    case (state_d)
      S_WLO:       tmr_val = TMR_W'(WP_C - 1);
      S_WHI:       tmr_val = TMR_W'(WH_C - 1);
      S_PRD, S_RD: tmr_val = TMR_W'(ACC_C - 1);
      S_RST:       tmr_val = TMR_W'(RST_C - 1);
      default:     tmr_val = '0;
    endcase
  end

  flash_seq_tmr #(.W(TMR_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      op_q    <= OP_READ;
      addr_q  <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      tmo_q   <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (accept) begin
        op_q   <= req_op_i;
        addr_q <= req_addr_i;
        data_q <= req_data_i;
        err_q  <= (req_op_i > OP_RESET);
        tmo_q  <= '0;
      end
      if ((state_q == S_PGAP || state_q == S_PRD) && tmo_q != '1)
        tmo_q <= tmo_q + TMO_W'(1);
      if (state_q == S_PRD && tmr_zero && !poll_done && tmo_q >= tmo_lim)
        err_q <= 1'b1;
      if (state_q == S_RD && tmr_zero)
        rdata_q <= fl_dq_i;
    end
  end

  // bus strobes registered from the next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_ce_no    <= 1'b1;
      fl_we_no    <= 1'b1;
      fl_oe_no    <= 1'b1;
      fl_rst_no   <= 1'b1;
      fl_dq_oe_o  <= 1'b0;
      fl_addr_o   <= '0;
      fl_dq_o     <= '0;
      req_ready_o <= 1'b1;
    end else begin
      fl_ce_no    <= !(state_d inside {S_WLO, S_PRD, S_RD});
      fl_we_no    <= (state_d != S_WLO);
      fl_oe_no    <= !(state_d inside {S_PRD, S_RD});
      fl_rst_no   <= (state_d != S_RST);
      fl_dq_oe_o  <= (state_d inside {S_WLO, S_WHI});
      req_ready_o <= (state_d == S_IDLE);
      if (accept) fl_addr_o <= req_addr_i;
      if (state_d == S_WLO && state_q != S_WLO) begin
        fl_addr_o <= cmd_addr;
        fl_dq_o   <= cmd_data;
      end
      if (state_d == S_PGAP) fl_addr_o <= addr_q;
    end
  end

  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_err_o   = err_q;
  assign rsp_data_o  = rdata_q;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int AW    = 21,
  parameter int DW    = 16,
  parameter int WP_C  = 12,
  parameter int WH_C  = 11,
  parameter int RST_C = 125
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_i,
  input logic          rsp_valid_i,
  input logic [AW-1:0] fl_addr_i,
  input logic [DW-1:0] fl_dq_i,
  input logic          fl_dq_oe_i,
  input logic          fl_ce_ni,
  input logic          fl_we_ni,
  input logic          fl_oe_ni,
  input logic          fl_rst_ni
);
  logic [15:0] we_lo_q, we_hi_q, rst_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_q  <= '0;
      we_hi_q  <= 16'hFFFF;
      rst_lo_q <= '0;
    end else begin
      we_lo_q  <= fl_we_ni  ? '0 : ((we_lo_q == 16'hFFFF) ? we_lo_q : we_lo_q + 16'd1);
      we_hi_q  <= !fl_we_ni ? '0 : ((we_hi_q == 16'hFFFF) ? we_hi_q : we_hi_q + 16'd1);
      rst_lo_q <= fl_rst_ni ? '0 : ((rst_lo_q == 16'hFFFF) ? rst_lo_q : rst_lo_q + 16'd1);
    end
  end

  assert_ready_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_i |-> (fl_ce_ni && fl_we_ni && fl_oe_ni && fl_rst_ni && !fl_dq_oe_i));

  assert_rsp_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> !rsp_valid_i);

  assert_we_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_ni) |-> (we_lo_q >= 16'(WP_C)));

  assert_we_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_we_ni) |-> (we_hi_q >= 16'(WH_C)));

  assert_no_contention_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_ni && !fl_oe_ni));

  assert_drive_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_dq_oe_i |-> fl_oe_ni);

  assert_wr_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_ni && $past(!fl_we_ni)) |-> ($stable(fl_addr_i) && $stable(fl_dq_i)));

  assert_oe_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_oe_ni) |-> $past(fl_oe_ni && fl_ce_ni));

  assert_rst_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_rst_ni) |-> (rst_lo_q >= 16'(RST_C)));

endmodule

bind flash_seq flash_seq_chk #(
  .AW(AW), .DW(DW), .WP_C(WP_C), .WH_C(WH_C), .RST_C(RST_C)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_i(req_ready_o), .rsp_valid_i(rsp_valid_o),
  .fl_addr_i(fl_addr_o), .fl_dq_i(fl_dq_o), .fl_dq_oe_i(fl_dq_oe_o), .fl_ce_ni(fl_ce_no),
  .fl_we_ni(fl_we_no), .fl_oe_ni(fl_oe_no), .fl_rst_ni(fl_rst_no)
);

// File: tb/sim_flash_seq.sv
`timescale 1ns/1ps
module sim_flash_seq;
  localparam int AW = 21, DW = 16;
  localparam int WP_C = 12, WH_C = 11, ACC_C = 23, RST_C = 125;
  localparam int PROG_LIM = 500;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_data, fl_dq_o, fl_dq_i;
  logic [AW-1:0] fl_addr;
  logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n;

  flash_seq #(.AW(AW), .DW(DW), .CLK_PS(4000), .PROG_TMO_US(2),
              .SERASE_TMO_US(3), .CERASE_TMO_US(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_data_o(rsp_data),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_no(fl_ce_n), .fl_we_no(fl_we_n), .fl_oe_no(fl_oe_n), .fl_rst_no(fl_rst_n)
  );

  int checks = 0, errors = 0, cyc = 0;

  // flash model: busy reads then done word
  int            busy_left = 0;
  logic [DW-1:0] busy_word = '0, done_word = '0;
  assign fl_dq_i = (busy_left > 0) ? busy_word : done_word;

  // monitor log
  logic [AW-1:0] wa[16];
  logic [DW-1:0] wd[16];
  int nw, nr, nrst, rst_w, bad_lo, bad_hi, bad6, bad7, bad_pa, oe_w;
  int we_lo, we_hi, oe_lo, rst_lo;
  logic p_we = 1'b1, p_oe = 1'b1, p_rst = 1'b1;
  logic [AW-1:0] p_addr = '0, tgt = '0;
  logic [DW-1:0] p_dq = '0;

  task automatic clear_log();
    nw = 0; nr = 0; nrst = 0; rst_w = 0; bad_lo = 0; bad_hi = 0;
    bad6 = 0; bad7 = 0; bad_pa = 0; oe_w = 0;
  endtask

  always @(negedge clk) begin
    if (!fl_we_n) begin
      if (p_we) begin
        if (nw > 0 && we_hi < WH_C) bad_hi++;
        if (!p_oe) bad7++;
        we_lo = 1;
      end else begin
        we_lo++;
        if (fl_addr != p_addr || fl_dq_o != p_dq) bad6++;
      end
    end else begin
      if (!p_we) begin
        if (nw < 16) begin wa[nw] = fl_addr; wd[nw] = fl_dq_o; end
        nw++;
        if (we_lo != WP_C) bad_lo++;
        we_hi = 1;
      end else we_hi++;
    end
    if (!fl_oe_n) begin
      oe_lo = p_oe ? 1 : oe_lo + 1;
      if (p_oe && !p_we) bad7++;
    end else if (!p_oe) begin
      nr++; oe_w = oe_lo;
      if (p_addr != tgt) bad_pa++;
      if (busy_left > 0) busy_left--;
    end
    if (!fl_rst_n) rst_lo = p_rst ? 1 : rst_lo + 1;
    else if (!p_rst) begin nrst++; rst_w = rst_lo; end
    if (fl_dq_oe && !fl_oe_n) bad6++;
    if (!fl_we_n && !fl_oe_n) bad6++;
    p_we = fl_we_n; p_oe = fl_oe_n; p_rst = fl_rst_n; p_addr = fl_addr; p_dq = fl_dq_o;
  end

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, logic ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected command stream, computed from the requirements
  function automatic int n_writes(logic [2:0] op);
    return (op == 3'd1) ? 4 : 6;
  endfunction

  function automatic logic [AW-1:0] exp_wa(logic [2:0] op, int k, logic [AW-1:0] a);
    if (op == 3'd1 && k == 3) return a;
    if (k == 5) return (op == 3'd2) ? a : AW'('h5555);
    return (k == 1 || k == 4) ? AW'('h2AAA) : AW'('h5555);
  endfunction

  function automatic logic [DW-1:0] exp_wd(logic [2:0] op, int k, logic [DW-1:0] d);
    logic [7:0] b;
    if (op == 3'd1) begin
      case (k) 0: b = 8'hAA; 1: b = 8'h55; 2: b = 8'hA0; default: return d; endcase
    end else begin
      case (k)
        0, 3: b = 8'hAA; 1, 4: b = 8'h55; 2: b = 8'h80;
        default: b = (op == 3'd2) ? 8'h30 : 8'h10;
      endcase
    end
    return {b, b};
  endfunction

  task automatic issue(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d, int wait_lim,
                       output int lat);
    clear_log();
    tgt = a;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 ready low after accept", req_ready == 1'b0, req_ready, 0);
    lat = 1;
    while (!rsp_valid && lat < wait_lim) begin @(negedge clk); lat++; end
    chk("R1 response seen", rsp_valid, rsp_valid, 1);
    @(negedge clk);
    chk("R1 single response, ready back", !rsp_valid && req_ready, {rsp_valid, req_ready}, 1);
  endtask

  task automatic run_wr(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d, int busy);
    int lat;
    string tag;
    tag = (op == 3'd1) ? "R2" : ((op == 3'd2) ? "R3" : "R4");
    if (op == 3'd1) begin
      done_word = d;
      busy_word = d ^ 16'h8080 ^ 16'h1234;
    end else begin
      done_word = 16'hFFFF;
      busy_word = 16'h5A3C;
    end
    busy_left = busy;
    issue(op, a, d, 5000, lat);
    chk({tag, " write count"}, nw == n_writes(op), nw, n_writes(op));
    for (int k = 0; k < n_writes(op) && k < 16; k++) begin
      chk({tag, " write address"}, wa[k] == exp_wa(op, k, a), wa[k], exp_wa(op, k, a));
      chk({tag, " write data"}, wd[k] == exp_wd(op, k, d), wd[k], exp_wd(op, k, d));
    end
    chk("R5 write low width", bad_lo == 0, bad_lo, 0);
    chk("R5 write high width", bad_hi == 0, bad_hi, 0);
    chk("R6 stable/drive", bad6 == 0, bad6, 0);
    chk("R7 oe gap", bad7 == 0, bad7, 0);
    chk("R8 poll reads", nr == busy + 1, nr, busy + 1);
    chk("R8 poll address", bad_pa == 0, bad_pa, 0);
    chk("R8 no error", rsp_err == 1'b0, rsp_err, 0);
  endtask

  task automatic run_rd(logic [AW-1:0] a, logic [DW-1:0] v);
    int lat;
    busy_left = 0; done_word = v;
    issue(3'd0, a, '0, 500, lat);
    chk("R11 read data", rsp_data == v, rsp_data, v);
    chk("R11 oe width", oe_w == ACC_C && nr == 1, oe_w, ACC_C);
    chk("R11 no write, no error", nw == 0 && !rsp_err, {nw, rsp_err}, 0);
    chk("R11 read address", bad_pa == 0, bad_pa, 0);
  endtask

  initial begin
    int lat;
    void'($urandom(32'd1357));
    clear_log();
    repeat (3) @(negedge clk);
    chk("R13 reset state", req_ready && fl_ce_n && fl_we_n && fl_oe_n && fl_rst_n
        && !fl_dq_oe && !rsp_valid, {req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n}, 5'h1f);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    run_wr(3'd1, 21'h0ABCD, 16'h807F, 0);    // lanes differ in bit 7
    run_wr(3'd1, 21'h1FFFFF, 16'h0080, 3);
    run_wr(3'd2, 21'h050000, 16'h0000, 2);
    run_wr(3'd3, 21'h000000, 16'h0000, 1);
    run_rd(21'h012345, 16'hBEEF);
    run_wr(3'd1, 21'h000010, 16'h8888, 1);   // write right after a read

    // device reset request
    busy_left = 0;
    issue(3'd4, 21'h0, 16'h0, 500, lat);
    chk("R10 reset width", nrst == 1 && rst_w == RST_C, rst_w, RST_C);
    chk("R10 no bus cycles, no error", nw == 0 && nr == 0 && !rsp_err, {nw, nr}, 0);

    // undefined opcodes
    for (int o = 5; o < 8; o++) begin
      issue(3'(o), 21'h00055, 16'h1111, 50, lat);
      chk("R12 error flag", rsp_err == 1'b1, rsp_err, 1);
      chk("R12 no activity", nw == 0 && nr == 0 && nrst == 0, nw + nr + nrst, 0);
      chk("R12 latency", lat <= 3, lat, 3);
    end

    // polling timeout on a program
    done_word = 16'h0101; busy_word = 16'h8181;
    busy_left = 1_000_000;
    issue(3'd1, 21'h003333, 16'h0101, 5000, lat);
    chk("R9 error flag", rsp_err == 1'b1, rsp_err, 1);
    chk("R9 reset pulse", nrst == 1 && rst_w == RST_C, rst_w, RST_C);
    chk("R9 poll reads before timeout", nr >= PROG_LIM / (ACC_C + 1), nr, PROG_LIM / (ACC_C + 1));
    busy_left = 0;

    // random mix
    for (int i = 0; i < 20; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 3));
      if (op == 3'd0) run_rd(AW'($urandom), DW'($urandom));
      else run_wr(op, AW'($urandom), DW'($urandom), int'($urandom_range(0, 4)));
    end

    finish_run();
  end
endmodule